// File: doc/BRIEF.md
# Interrupt Acknowledge Arbiter

This block settles which interrupt source answers an interrupt acknowledge cycle. A set of on-chip modules each present a 3-bit request level, a vector number and a programmable 4-bit arbitration value. One further source, the system integration unit, merges two requesters of its own: a periodic timer with a 3-bit level and its own vector, and the external interrupt pins with an encoded 3-bit level. When the processor starts an acknowledge cycle for a level, every source requesting at exactly that level contends on its arbitration value. Contention runs even when only one source is requesting.

An on-chip winner, or the timer inside the integration unit, ends the cycle with its vector and an internal termination. If the integration unit wins on behalf of the pins, the cycle is handed to the external bus. There it ends on a device vector with data-size acknowledge, on an autovector request, or on a bus-monitor timeout that gives a bus error and the spurious vector. Acknowledge and autovector strobes from the chip-select logic are accepted only while a cycle is forwarded. A cycle in which no source wins ends at once with a bus error.

Top module: `iack_arbiter`

## Requirements
- R1: Out of reset the arbitration value of every on-chip module is 0 and that of the integration unit (index N_MOD) is 15; done, ext_fwd and coll_err are 0.
- R2: The winner is the contender at the acknowledged level with the largest arbitration value; on equal values the lowest index wins (modules 0..N_MOD-1, integration unit N_MOD).
- R3: A source with arbitration value 0 never wins; if no source can win, done rises one cycle after iack_start with done_berr=1 and done_vec=8'h18.
- R4: An on-chip winner ends the cycle one cycle after iack_start with done=1, done_int=1, done_avec=0 and done_vec equal to that module's vector. done is a one-cycle pulse.
- R5: ext_fwd rises one cycle after iack_start only when the integration unit wins and the timer is not requesting at that level; when the timer requests at the acknowledged level the integration unit ends the cycle internally with the timer vector.
- R6: While forwarded, a data-size acknowledge (ext_dsack or cs_dsack) ends the cycle one cycle later with done_vec=ext_vec and done_int=done_avec=done_berr=0; an autovector request (ext_avec or cs_avec) ends it with done_avec=1 and done_vec=8'h18 plus the level; acknowledge beats autovector when both are seen in the same cycle.
- R7: With bmon_en=1, a forwarded cycle that receives no response for BMON_CYCLES cycles ends with done_berr=1 and done_vec=8'h18; with bmon_en=0 it waits indefinitely.
- R8: cs_dsack and cs_avec have no effect on a cycle won by an on-chip source.
- R9: A timer level of 3'b000 means the timer does not request.
- R10: When two contenders at the acknowledged level share a nonzero arbitration value, coll_err is set and stays set until reset.
- R11: iack_start is ignored while a forwarded cycle is outstanding.
- R12: A write with cfg_we=1 loads cfg_pri into the arbitration value of source cfg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Arbitration value write strobe |
| cfg_idx | input | IDX_W | Source index to write (N_MOD = integration unit) |
| cfg_pri | input | 4 | Arbitration value to write |
| mod_level | input | 3*N_MOD | Request level per on-chip module, 0 = none |
| mod_vec | input | 8*N_MOD | Vector number per on-chip module |
| tmr_req | input | 1 | Periodic timer request |
| tmr_level | input | 3 | Periodic timer level, 0 disables |
| tmr_vec | input | 8 | Periodic timer vector |
| pin_level | input | 3 | Encoded external pin request level, 0 = none |
| iack_start | input | 1 | Acknowledge cycle start pulse |
| iack_level | input | 3 | Level being acknowledged |
| ext_dsack | input | 1 | External device data-size acknowledge |
| ext_avec | input | 1 | External autovector request |
| ext_vec | input | 8 | Vector from external device |
| cs_dsack | input | 1 | Chip-select generated acknowledge |
| cs_avec | input | 1 | Chip-select generated autovector request |
| bmon_en | input | 1 | Bus monitor enable |
| ext_fwd | output | 1 | Cycle forwarded to external bus |
| done | output | 1 | Cycle terminated (pulse) |
| done_vec | output | 8 | Vector number for the ended cycle |
| done_int | output | 1 | Ended with internal termination |
| done_avec | output | 1 | Ended by autovector |
| done_berr | output | 1 | Ended by bus error |
| coll_err | output | 1 | Sticky equal-value collision flag |

## Verification
The bench builds the block with N_MOD=4 and BMON_CYCLES=8. Four modules plus the integration unit give a five-way contest in which ties, zero values and the timer-versus-pins split inside the integration unit all occur often under random levels. The short monitor window lets the timeout be reached and checked to the exact cycle, next to a disabled-monitor wait much longer than the window.

// File: rtl/iack_arb_pkg.sv
package iack_arb_pkg;
  localparam int LVL_W = 3;
  localparam int PRI_W = 4;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] SPUR_VEC = 8'h18;

  typedef enum logic [1:0] {WIN_NONE, WIN_INT, WIN_EXT} win_kind_e;
  typedef enum logic {SQ_IDLE, SQ_EXT} seq_state_e;

  function automatic logic [VEC_W-1:0] autovec_num(input logic [LVL_W-1:0] lvl);
    return SPUR_VEC + {{(VEC_W-LVL_W){1'b0}}, lvl};
  endfunction

  function automatic logic lvl_hit(input logic [LVL_W-1:0] req, input logic [LVL_W-1:0] ack);
    return (req != '0) && (req == ack);
  endfunction
endpackage

// File: rtl/iack_prio_regs.sv
module iack_prio_regs
  import iack_arb_pkg::*;
#(
  parameter int N_SRC = 5,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [PRI_W-1:0]             cfg_pri,
  output logic [N_SRC-1:0][PRI_W-1:0]  pri_q
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_reg
    localparam logic [PRI_W-1:0] RST_VAL = (g == N_SRC-1) ? '1 : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 pri_q[g] <= RST_VAL;
      else if (cfg_we && cfg_idx == IDX_W'(g))    pri_q[g] <= cfg_pri;
    end
  end
endmodule

// File: rtl/iack_contend.sv
module iack_contend
  import iack_arb_pkg::*;
#(
  parameter int N_SRC = 5,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             hit,
  input  logic [N_SRC-1:0][PRI_W-1:0]  pri,
  output logic                         win_valid,
  output logic [IDX_W-1:0]             win_idx,
  output logic                         collide
);
  logic [PRI_W-1:0] best_pri;

  always_comb begin
    best_pri  = '0;
    win_idx   = '0;
    win_valid = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit[i] && pri[i] > best_pri) begin
        best_pri  = pri[i];
        win_idx   = IDX_W'(i);
        win_valid = 1'b1;
      end
    end
  end

  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      for (int j = i + 1; j < N_SRC; j++)
        if (hit[i] && hit[j] && pri[i] != '0 && pri[i] == pri[j])
          collide = 1'b1;
  end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_arb_pkg::*;
#(
  parameter int BMON_CYCLES = 16,
  localparam int CNT_W = $clog2(BMON_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  win_kind_e        kind,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic [VEC_W-1:0] int_vec,
  input  logic             rsp_dsack,
  input  logic             rsp_avec,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic             bmon_en,
  output logic             busy,
  output logic             ext_fwd,
  output logic             done,
  output logic [VEC_W-1:0] done_vec,
  output logic             done_int,
  output logic             done_avec,
  output logic             done_berr
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BMON_CYCLES - 1);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] lvl_q;
  logic             bmon_expire;

  assign busy        = (st_q != SQ_IDLE);
  assign ext_fwd     = (st_q == SQ_EXT);
  assign bmon_expire = ext_fwd && bmon_en && (cnt_q == CNT_LAST) && !rsp_dsack && !rsp_avec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      lvl_q     <= '0;
      done      <= 1'b0;
      done_vec  <= '0;
      done_int  <= 1'b0;
      done_avec <= 1'b0;
      done_berr <= 1'b0;
    end else begin
      done      <= 1'b0;
      done_int  <= 1'b0;
      done_avec <= 1'b0;
      done_berr <= 1'b0;
      case (st_q)
        SQ_IDLE: if (accept) begin
          case (kind)
            WIN_INT: begin
              done     <= 1'b1;
              done_int <= 1'b1;
              done_vec <= int_vec;
            end
            WIN_EXT: begin
              st_q  <= SQ_EXT;
              cnt_q <= '0;
              lvl_q <= ack_lvl;
            end
            default: begin
              done      <= 1'b1;
              done_berr <= 1'b1;
              done_vec  <= SPUR_VEC;
            end
          endcase
        end
        SQ_EXT: begin
          if (rsp_dsack) begin
            done     <= 1'b1;
            done_vec <= ext_vec;
            st_q     <= SQ_IDLE;
          end else if (rsp_avec) begin
            done      <= 1'b1;
            done_avec <= 1'b1;
            done_vec  <= autovec_num(lvl_q);
            st_q      <= SQ_IDLE;
          end else if (bmon_expire) begin
            done      <= 1'b1;
            done_berr <= 1'b1;
            done_vec  <= SPUR_VEC;
            st_q      <= SQ_IDLE;
          end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_TERM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({done_int, done_avec, done_berr})); // R6
  AST_BMON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    bmon_expire |=> (done && done_berr && !ext_fwd)); // R7
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fwd && !rsp_dsack && !rsp_avec && !bmon_expire) |=> (ext_fwd && !done)); // R11
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter
  import iack_arb_pkg::*;
#(
  parameter int N_MOD       = 4,
  parameter int BMON_CYCLES = 16,
  localparam int N_SRC = N_MOD + 1,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [3:0]         cfg_pri,
  input  logic [3*N_MOD-1:0] mod_level,
  input  logic [8*N_MOD-1:0] mod_vec,
  input  logic               tmr_req,
  input  logic [2:0]         tmr_level,
  input  logic [7:0]         tmr_vec,
  input  logic [2:0]         pin_level,
  input  logic               iack_start,
  input  logic [2:0]         iack_level,
  input  logic               ext_dsack,
  input  logic               ext_avec,
  input  logic [7:0]         ext_vec,
  input  logic               cs_dsack,
  input  logic               cs_avec,
  input  logic               bmon_en,
  output logic               ext_fwd,
  output logic               done,
  output logic [7:0]         done_vec,
  output logic               done_int,
  output logic               done_avec,
  output logic               done_berr,
  output logic               coll_err
);
  logic [N_SRC-1:0][PRI_W-1:0] pri_q;
  logic [N_SRC-1:0]            hit;
  logic                        tmr_hit, pin_hit;
  logic                        win_valid, collide, busy, accept, win_sys;
  logic [IDX_W-1:0]            win_idx;
  win_kind_e                   kind;
  logic [VEC_W-1:0]            int_vec;

  iack_prio_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_pri(cfg_pri), .pri_q(pri_q)
  );

  for (genvar g = 0; g < N_MOD; g++) begin : g_hit
    assign hit[g] = lvl_hit(mod_level[3*g +: 3], iack_level);
  end
  assign tmr_hit    = tmr_req && lvl_hit(tmr_level, iack_level);
  assign pin_hit    = lvl_hit(pin_level, iack_level);
  assign hit[N_MOD] = tmr_hit || pin_hit;

  iack_contend #(.N_SRC(N_SRC)) u_contend (
    .hit(hit), .pri(pri_q), .win_valid(win_valid), .win_idx(win_idx), .collide(collide)
  );

  assign win_sys = win_valid && (win_idx == IDX_W'(N_MOD));
  assign accept  = iack_start && !busy;

  always_comb begin
    kind    = WIN_NONE;
    int_vec = tmr_vec;
    if (win_sys) begin
      kind = tmr_hit ? WIN_INT : WIN_EXT;
    end else if (win_valid) begin
      kind = WIN_INT;
      for (int i = 0; i < N_MOD; i++)
        if (win_idx == IDX_W'(i)) int_vec = mod_vec[8*i +: 8];
    end
  end

  iack_seq #(.BMON_CYCLES(BMON_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .kind(kind), .ack_lvl(iack_level),
    .int_vec(int_vec), .rsp_dsack(ext_dsack || cs_dsack), .rsp_avec(ext_avec || cs_avec),
    .ext_vec(ext_vec), .bmon_en(bmon_en), .busy(busy), .ext_fwd(ext_fwd), .done(done),
    .done_vec(done_vec), .done_int(done_int), .done_avec(done_avec), .done_berr(done_berr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  coll_err <= 1'b0;
    else if (accept && collide)  coll_err <= 1'b1;
  end

  AST_FWD_SYS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_fwd) |-> $past(accept && win_sys && !tmr_hit)); // R5
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    coll_err |=> coll_err); // R10
  AST_NO_WIN_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_valid) |=> (done && done_berr)); // R3
  AST_INT_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_valid && !win_sys) |=> (done && done_int && !ext_fwd)); // R8
endmodule

// File: tb/iack_arbiter_tb_top.sv
module iack_arbiter_tb_top;
  localparam int NM = 4;
  localparam int BM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_idx = 0; logic [3:0] cfg_pri = 0;
  logic [3*NM-1:0] mod_level; logic [8*NM-1:0] mod_vec;
  logic tmr_req = 0; logic [2:0] tmr_level = 0; logic [7:0] tmr_vec = 8'hC5;
  logic [2:0] pin_level = 0;
  logic iack_start = 0; logic [2:0] iack_level = 0;
  logic ext_dsack = 0, ext_avec = 0, cs_dsack = 0, cs_avec = 0, bmon_en = 1;
  logic [7:0] ext_vec = 0;
  logic ext_fwd, done, done_int, done_avec, done_berr, coll_err;
  logic [7:0] done_vec;

  logic [2:0] m_lvl [NM];
  logic [7:0] m_vec [NM];
  logic [3:0] m_pri [NM+1];
  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;
  bit exp_coll = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NM; i++) begin
      mod_level[3*i +: 3] = m_lvl[i];
      mod_vec[8*i +: 8]   = m_vec[i];
    end

  iack_arbiter #(.N_MOD(NM), .BMON_CYCLES(BM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pri(cfg_pri),
    .mod_level(mod_level), .mod_vec(mod_vec), .tmr_req(tmr_req), .tmr_level(tmr_level),
    .tmr_vec(tmr_vec), .pin_level(pin_level), .iack_start(iack_start), .iack_level(iack_level),
    .ext_dsack(ext_dsack), .ext_avec(ext_avec), .ext_vec(ext_vec), .cs_dsack(cs_dsack),
    .cs_avec(cs_avec), .bmon_en(bmon_en), .ext_fwd(ext_fwd), .done(done), .done_vec(done_vec),
    .done_int(done_int), .done_avec(done_avec), .done_berr(done_berr), .coll_err(coll_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic set_pri(input int idx, input logic [3:0] v);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_pri = v;
    @(negedge clk); cfg_we = 0;
    m_pri[idx] = v;
  endtask

  // start a cycle; returns at the negedge after the accepting edge
  task automatic go(input logic [2:0] lvl);
    @(negedge clk); iack_start = 1; iack_level = lvl;
    @(negedge clk); iack_start = 0;
  endtask

  // one-cycle response strobe, returns after the edge that samples it
  task automatic respond(input bit ds, input bit av, input bit use_cs, input logic [7:0] v);
    ext_vec = v;
    if (use_cs) begin cs_dsack = ds; cs_avec = av; end
    else begin ext_dsack = ds; ext_avec = av; end
    @(negedge clk);
    ext_dsack = 0; ext_avec = 0; cs_dsack = 0; cs_avec = 0;
  endtask

  // bench model: kind 0 none, 1 internal, 2 forwarded
  task automatic model(input logic [2:0] al, output int kind, output logic [7:0] vec, output bit coll);
    bit h [NM+1];
    bit th;
    int best, first;
    int cnt [16];
    th = tmr_req && tmr_level != 0 && tmr_level == al;
    for (int i = 0; i < NM; i++) h[i] = (m_lvl[i] != 0) && (m_lvl[i] == al);
    h[NM] = th || (pin_level != 0 && pin_level == al);
    for (int v = 0; v < 16; v++) cnt[v] = 0;
    best = 0;
    for (int i = 0; i <= NM; i++) if (h[i]) begin
      cnt[m_pri[i]]++;
      if (m_pri[i] > best) best = m_pri[i];
    end
    coll = 0;
    for (int v = 1; v < 16; v++) if (cnt[v] > 1) coll = 1;
    first = -1;
    for (int i = NM; i >= 0; i--) if (h[i] && best != 0 && m_pri[i] == best) first = i;
    vec = 8'h18;
    if (first < 0) kind = 0;
    else if (first < NM) begin kind = 1; vec = m_vec[first]; end
    else if (th) begin kind = 1; vec = tmr_vec; end
    else kind = 2;
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int k; logic [7:0] ev; bit cl;
    process::self().srandom(32'h1AC5);
    for (int i = 0; i < NM; i++) begin m_lvl[i] = 0; m_vec[i] = 8'(8'h40 + i); m_pri[i] = 0; end
    m_pri[NM] = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 ext_fwd", ext_fwd, 0);
    chk("R1 coll_err", coll_err, 0);

    // R1/R3: module 0 requests with reset value 0 -> no winner
    m_lvl[0] = 3;
    go(3);
    chk("R3 no winner done", done, 1);
    chk("R3 no winner berr", done_berr, 1);
    chk("R3 spurious vec", done_vec, 8'h18);

    // R1/R5: pins at 3 with integration value 15 -> forwarded
    pin_level = 3;
    go(3);
    chk("R5 forwarded", ext_fwd, 1);
    chk("R5 no done", done, 0);
    respond(1, 0, 0, 8'h77);
    chk("R6 dsack done", done, 1);
    chk("R6 dsack vec", done_vec, 8'h77);
    chk("R6 dsack not int", done_int, 0);
    chk("R6 fwd cleared", ext_fwd, 0);
    pin_level = 0; m_lvl[0] = 0;

    // R12/R2/R4/R8: modules 0,1 at level 4, values 5 and 9, chip-select strobes present
    set_pri(0, 5); set_pri(1, 9);
    m_lvl[0] = 4; m_lvl[1] = 4;
    cs_avec = 1; cs_dsack = 1;
    go(4);
    cs_avec = 0; cs_dsack = 0;
    chk("R12 R2 winner vec", done_vec, m_vec[1]);
    chk("R4 done_int", done_int, 1);
    chk("R8 no avec", done_avec, 0);
    chk("R8 no fwd", ext_fwd, 0);
    @(negedge clk);
    chk("R4 pulse", done, 0);

    // R6: autovector via chip select, then both strobes
    m_lvl[0] = 0; m_lvl[1] = 0; pin_level = 2;
    go(2);
    respond(0, 1, 1, 8'h00);
    chk("R6 avec flag", done_avec, 1);
    chk("R6 avec vec", done_vec, 8'h1A);
    go(2);
    respond(1, 1, 0, 8'h5C);
    chk("R6 dsack over avec", done_vec, 8'h5C);
    chk("R6 dsack over avec flag", done_avec, 0);

    // R5/R9: timer at pin level wins internally; level 0 disables it
    pin_level = 5; tmr_req = 1; tmr_level = 5;
    go(5);
    chk("R5 timer internal", done_int, 1);
    chk("R5 timer vec", done_vec, tmr_vec);
    tmr_level = 0;
    go(5);
    chk("R9 timer disabled fwd", ext_fwd, 1);
    respond(1, 0, 0, 8'h33);

    // R7: monitor timeout at BM cycles; R11 start ignored while outstanding
    go(5);
    m_lvl[2] = 6; set_pri(2, 3);
    @(negedge clk); iack_start = 1; iack_level = 6;
    @(negedge clk); iack_start = 0;
    chk("R11 start ignored", ext_fwd, 1);
    chk("R11 no done", done, 0);
    repeat (BM - 5) @(negedge clk);
    chk("R7 before timeout", done, 0);
    @(negedge clk);
    chk("R7 timeout done", done, 1);
    chk("R7 timeout berr", done_berr, 1);
    chk("R7 timeout vec", done_vec, 8'h18);
    bmon_en = 0;
    go(5);
    repeat (3 * BM) @(negedge clk);
    chk("R7 disabled waits", ext_fwd, 1);
    respond(0, 1, 0, 8'h00);
    chk("R7 disabled end", done_vec, 8'h1D);
    bmon_en = 1;

    // R10: modules 2 and 3 share value 7 at level 6
    set_pri(2, 7); set_pri(3, 7); m_lvl[3] = 6;
    go(6);
    chk("R10 tie lowest index", done_vec, m_vec[2]);
    chk("R10 coll set", coll_err, 1);
    m_lvl[3] = 0;
    go(6);
    chk("R10 coll sticky", coll_err, 1);
    exp_coll = 1;
    pin_level = 0; tmr_req = 0; m_lvl[2] = 0;

    // random phase
    for (int it = 0; it < 250; it++) begin
      logic [2:0] al;
      for (int i = 0; i <= NM; i++) set_pri(i, 4'($urandom_range(0, 15)));
      for (int i = 0; i < NM; i++) begin m_lvl[i] = 3'($urandom); m_vec[i] = 8'($urandom); end
      tmr_req = 1'($urandom); tmr_level = 3'($urandom); tmr_vec = 8'($urandom);
      pin_level = 3'($urandom);
      al = 3'($urandom_range(1, 7));
      model(al, k, ev, cl);
      if (cl) exp_coll = 1;
      go(al);
      if (k == 2) begin
        int r; logic [7:0] xv;
        chk("R5 rnd fwd", ext_fwd, 1);
        r = $urandom_range(0, 2); xv = 8'($urandom);
        respond(r != 1, r != 0, 1'($urandom), xv);
        chk("R6 rnd vec", done_vec, (r != 1) ? xv : 8'(8'h18 + al));
        chk("R6 rnd avec", done_avec, r == 1);
      end else begin
        chk("R2 rnd done", done, 1);
        chk("R2 rnd vec", done_vec, ev);
        chk("R3 rnd berr", done_berr, k == 0);
        chk("R4 rnd int", done_int, k == 1);
      end
      chk("R10 rnd coll", coll_err, exp_coll);
    end
    finish_run();
  end
endmodule